// File: doc/BRIEF.md
# Serial Boot Command Protocol Handler

This block runs the target side of a byte-level boot handshake. It sits between a serial receiver and a serial transmitter that are outside the block. The first byte from the host can have any value. That byte turns the receiver on, and the block answers with the go-ahead byte 0x30. From then on the block waits for command bytes. It either echoes each command or rejects it with a coded error byte. The RAM-transfer command (0x10) opens a password stage. In that stage a fixed number of password bytes (12 by default) are compared with a reference password supplied on an input bus. A checksum byte follows, and the block then sends one final acknowledge.

Both byte streams use valid/ready handshakes. A received byte is taken on any cycle where `rx_valid` and `rx_ready` are both high. The block lowers `rx_ready` while a response is waiting to go out, so the host side stalls until the response has been sent. A response is offered on `tx_valid`. It holds `tx_data` unchanged until the cycle where `tx_ready` is high, and that cycle completes the transfer. The `sync_mode` input selects clocked serial operation, in which receive errors are ignored.

Top module: `boot_cmd_handler`

## Requirements
- R1: In the cycle after a synchronous reset, `tx_valid` is 0, `rx_ready` is 1, `rx_enable`, `pw_err` and `cks_err` are 0, and the stored last command is 0x00.
- R2: The first byte taken after reset, whatever its value, sets `rx_enable` (it then stays set until reset) and produces the response 0x30.
- R3: `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low. `rx_ready` is low while a response is pending. Each taken command or first byte yields exactly one response, and so does each taken checksum byte.
- R4: The command byte 0x10 is echoed as 0x10, and the block then enters the password stage (`pw_busy` high).
- R5: In asynchronous mode (`sync_mode`=0), a command byte that arrives with `rx_err` high is answered with {last command[7:4], 4'b1000}. The stored last command does not change, and the block keeps waiting for a command.
- R6: In synchronous mode (`sync_mode`=1), `rx_err` is ignored, and the byte is handled as if no error had been flagged.
- R7: A command byte other than 0x10 that arrives without a reported error is answered with {last command[7:4], 4'b0001}. That byte then becomes the stored last command, and the block keeps waiting for a command.
- R8: During the password stage, password byte i is compared with `ref_pw[8*i+7:8*i]`, where byte 0 is the first byte received. Any mismatch sets `pw_err`, which stays set until the next 0x10 command clears it. No response is sent for password bytes.
- R9: The checksum byte is valid when (sum of the password bytes + checksum) mod 256 is 0. `cks_err` is updated when the checksum byte is taken.
- R10: After the checksum byte, the block sends 0x10 if both the password and the checksum are good. Otherwise it sends 0x10 with bit 2 set for a password error and bit 1 set for a checksum error (0x14, 0x12 or 0x16). It then waits for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received byte is available |
| rx_ready | output | 1 | Block can take a received byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive error flag for the current byte |
| tx_valid | output | 1 | Response byte is available |
| tx_ready | input | 1 | Transmitter takes the response byte |
| tx_data | output | 8 | Response byte |
| ref_pw | input | 8*PW_LEN | Reference password, byte 0 in bits 7:0 |
| sync_mode | input | 1 | 1 = clocked serial, receive errors ignored |
| rx_enable | output | 1 | Receiver enabled after the first byte |
| pw_busy | output | 1 | Password or checksum byte expected |
| pw_err | output | 1 | Sticky password mismatch flag |
| cks_err | output | 1 | Checksum of the last password stage was bad |

## Verification
Every response is registered, so `tx_valid` and its byte appear in the cycle after the edge that takes the input byte. The status flags change at that same edge. The bench drives inputs on the falling edge and samples one nanosecond after it. It therefore sees each response and flag exactly one edge after the edge that takes the byte. A scoreboard queue holds the expected response bytes in order, and the monitor pops one for every completed transmit handshake. A stray response during a password stage, or a missing response, shows up as a queue mismatch. A back-pressure case holds `tx_ready` low for several cycles and checks that the response stays pending and the receive side stays stalled.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_CMD,
    ST_PW,
    ST_CKS,
    ST_TX
  } boot_st_e;

  localparam logic [7:0] GO_BYTE  = 8'h30;
  localparam logic [7:0] CMD_RAM  = 8'h10;
  localparam int BIT_BADCMD = 0;
  localparam int BIT_CKSERR = 1;
  localparam int BIT_PWERR  = 2;
  localparam int BIT_RXERR  = 3;
endpackage

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode
  import boot_cmd_pkg::*;
(
  input  logic [7:0] cmd_in,
  input  logic       rx_err,
  input  logic       sync_mode,
  input  logic [7:0] last_cmd,
  output logic [7:0] ack,
  output logic       is_ram,
  output logic       upd_last
);
  logic err_seen;
  assign err_seen = rx_err && !sync_mode;

  always_comb begin
    ack      = {last_cmd[7:4], 4'b0000};
    is_ram   = 1'b0;
    upd_last = 1'b0;
    if (err_seen) begin
      ack[BIT_RXERR] = 1'b1;
    end else if (cmd_in == CMD_RAM) begin
      ack      = cmd_in;
      is_ram   = 1'b1;
      upd_last = 1'b1;
    end else begin
      ack[BIT_BADCMD] = 1'b1;
      upd_last        = 1'b1;
    end
  end
endmodule

// File: rtl/boot_pw_check.sv
module boot_pw_check #(
  parameter int PW_LEN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              byte_fire,
  input  logic              cks_fire,
  input  logic [7:0]        byte_in,
  input  logic [8*PW_LEN-1:0] ref_pw,
  output logic              pw_last,
  output logic              cks_ok,
  output logic              pw_err,
  output logic              cks_err
);
  localparam int IW = (PW_LEN > 2) ? $clog2(PW_LEN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(PW_LEN - 1);

  logic [IW-1:0] idx;
  logic [7:0]    sum;
  logic [7:0]    ref_byte;
  logic [7:0]    total;

  assign ref_byte = ref_pw[idx*8 +: 8];
  assign pw_last  = (idx == LAST_IDX);
  assign total    = sum + byte_in;
  assign cks_ok   = (total == 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      sum     <= '0;
      pw_err  <= 1'b0;
      cks_err <= 1'b0;
    end else if (clear) begin
      idx     <= '0;
      sum     <= '0;
      pw_err  <= 1'b0;
      cks_err <= 1'b0;
    end else begin
      if (byte_fire) begin
        sum <= total;
        if (byte_in != ref_byte) pw_err <= 1'b1;
        if (!pw_last) idx <= idx + 1'b1;
      end
      if (cks_fire) cks_err <= !cks_ok;
    end
  end
endmodule

// File: rtl/boot_tx_slot.sv
module boot_tx_slot (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_cmd_handler.sv
module boot_cmd_handler
  import boot_cmd_pkg::*;
#(
  parameter int PW_LEN = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [7:0]          rx_data,
  input  logic                rx_err,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [7:0]          tx_data,
  input  logic [8*PW_LEN-1:0] ref_pw,
  input  logic                sync_mode,
  output logic                rx_enable,
  output logic                pw_busy,
  output logic                pw_err,
  output logic                cks_err
);
  boot_st_e   state, state_n, ret_q, ret_n;
  logic [7:0] last_cmd;
  logic       rx_fire, tx_fire;
  logic       load;
  logic [7:0] load_data;
  logic [7:0] dec_ack;
  logic       dec_ram, dec_upd;
  logic       pw_clear, byte_fire, cks_fire;
  logic       pw_last, cks_ok;
  logic [7:0] fin_byte;

  assign rx_ready = (state == ST_START) || (state == ST_CMD) ||
                    (state == ST_PW) || (state == ST_CKS);
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign pw_busy  = (state == ST_PW) || (state == ST_CKS);

  boot_cmd_decode u_dec (
    .cmd_in    (rx_data),
    .rx_err    (rx_err),
    .sync_mode (sync_mode),
    .last_cmd  (last_cmd),
    .ack       (dec_ack),
    .is_ram    (dec_ram),
    .upd_last  (dec_upd)
  );

  boot_pw_check #(.PW_LEN(PW_LEN)) u_pw (
    .clk       (clk),
    .rst       (rst),
    .clear     (pw_clear),
    .byte_fire (byte_fire),
    .cks_fire  (cks_fire),
    .byte_in   (rx_data),
    .ref_pw    (ref_pw),
    .pw_last   (pw_last),
    .cks_ok    (cks_ok),
    .pw_err    (pw_err),
    .cks_err   (cks_err)
  );

  boot_tx_slot u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (load_data),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
  );

  always_comb begin
    fin_byte = {last_cmd[7:4], 4'b0000};
    if (pw_err || !cks_ok) begin
      fin_byte[BIT_PWERR]  = pw_err;
      fin_byte[BIT_CKSERR] = !cks_ok;
    end
  end

  always_comb begin
    state_n   = state;
    ret_n     = ret_q;
    load      = 1'b0;
    load_data = 8'h00;
    pw_clear  = 1'b0;
    byte_fire = 1'b0;
    cks_fire  = 1'b0;
    case (state)
      ST_START: if (rx_fire) begin
        load      = 1'b1;
        load_data = GO_BYTE;
        state_n   = ST_TX;
        ret_n     = ST_CMD;
      end
      ST_CMD: if (rx_fire) begin
        load      = 1'b1;
        load_data = dec_ack;
        pw_clear  = dec_ram;
        state_n   = ST_TX;
        ret_n     = dec_ram ? ST_PW : ST_CMD;
      end
      ST_PW: if (rx_fire) begin
        byte_fire = 1'b1;
        if (pw_last) state_n = ST_CKS;
      end
      ST_CKS: if (rx_fire) begin
        cks_fire  = 1'b1;
        load      = 1'b1;
        load_data = fin_byte;
        state_n   = ST_TX;
        ret_n     = ST_CMD;
      end
      ST_TX: if (tx_fire) state_n = ret_q;
      default: state_n = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_START;
      ret_q     <= ST_CMD;
      rx_enable <= 1'b0;
      last_cmd  <= 8'h00;
    end else begin
      state <= state_n;
      ret_q <= ret_n;
      if (state == ST_START && rx_fire) rx_enable <= 1'b1;
      if (state == ST_CMD && rx_fire && dec_upd) last_cmd <= rx_data;
    end
  end
endmodule

// File: rtl/boot_cmd_handler_chk.sv
module boot_cmd_handler_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rx_enable,
  input logic       pw_busy,
  input logic       pw_err,
  input logic       cks_err
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && rx_ready && !rx_enable && !pw_err && !cks_err)); // R1
  AST_GO_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_enable) |-> (tx_valid && tx_data == 8'h30)); // R2
  AST_RXEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    rx_enable |=> rx_enable); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R3
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !rx_ready); // R3
  AST_RXERR_FORM: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_data[3]) |-> (tx_data[2:0] == 3'b000)); // R5
  AST_PW_QUIET: assert property (@(posedge clk) disable iff (rst)
    pw_busy |-> !tx_valid); // R8
  AST_FIN_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $fell(pw_busy) |-> (tx_valid && ((tx_data == 8'h10) == (!pw_err && !cks_err)))); // R10
endmodule

bind boot_cmd_handler boot_cmd_handler_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .rx_enable (rx_enable),
  .pw_busy   (pw_busy),
  .pw_err    (pw_err),
  .cks_err   (cks_err)
);

// File: tb/boot_cmd_handler_test.sv
module boot_cmd_handler_test;
  localparam int PW_LEN = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst = 1'b1;
  logic                rx_valid = 1'b0;
  logic                rx_ready;
  logic [7:0]          rx_data = 8'h00;
  logic                rx_err = 1'b0;
  logic                tx_valid;
  logic                tx_ready = 1'b1;
  logic [7:0]          tx_data;
  logic [8*PW_LEN-1:0] ref_pw;
  logic                sync_mode = 1'b0;
  logic                rx_enable, pw_busy, pw_err, cks_err;

  boot_cmd_handler #(.PW_LEN(PW_LEN)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_err(rx_err), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .ref_pw(ref_pw),
    .sync_mode(sync_mode), .rx_enable(rx_enable), .pw_busy(pw_busy),
    .pw_err(pw_err), .cks_err(cks_err)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: one expected byte per completed transmit handshake
  logic       holding = 1'b0;
  logic [7:0] held = 8'h00;
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (holding) check("R3", "pending byte held", {tx_valid, tx_data}, {1'b1, held});
      if (tx_valid) check("R3", "rx_ready low while pending", rx_ready, 0);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check("R3", "unexpected response", tx_data, 8'hxx === 8'hxx ? 9'h100 : 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, "response byte", tx_data, e);
        end
      end
      holding = tx_valid && !tx_ready;
      held    = tx_data;
    end
  end

  task automatic expect_tx(logic [7:0] b, string req);
    exp_q.push_back(b);
    tag_q.push_back(req);
  endtask

  task automatic put(logic [7:0] d, logic e);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    rx_err   = e;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    rx_err   = 1'b0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    #2;
    check(req, "all responses seen", exp_q.size(), 0);
  endtask

  task automatic run_pw(int bad_idx, bit bad_cks, logic [7:0] fin, string req);
    logic [7:0] s;
    logic [7:0] b;
    s = 8'h00;
    for (int i = 0; i < PW_LEN; i++) begin
      b = ref_pw[i*8 +: 8];
      if (i == bad_idx) b = b ^ 8'h5A;
      s = s + b;
      put(b, 1'b0);
    end
    b = 8'h00 - s;
    if (bad_cks) b = b + 8'h01;
    expect_tx(fin, req);
    put(b, 1'b0);
    drain(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < PW_LEN; i++) ref_pw[i*8 +: 8] = 8'h3C + 8'(i * 29);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    check("R1", "tx_valid", tx_valid, 0);
    check("R1", "rx_ready", rx_ready, 1);
    check("R1", "rx_enable", rx_enable, 0);
    check("R1", "flags", {pw_err, cks_err}, 0);

    // R2 first byte of any value
    expect_tx(8'h30, "R2");
    put(8'h86, 1'b1);
    drain("R2");
    check("R2", "rx_enable", rx_enable, 1);

    // R5 error ack carries upper nibble of reset last command (R1)
    expect_tx(8'h08, "R5");
    put(8'h10, 1'b1);
    // R7 bad command
    expect_tx(8'h01, "R7");
    put(8'h5A, 1'b0);
    expect_tx(8'h58, "R5");
    put(8'h33, 1'b1);
    expect_tx(8'h51, "R7");
    put(8'h77, 1'b0);
    drain("R7");

    // R4 with back-pressure (R3)
    tx_ready = 1'b0;
    expect_tx(8'h10, "R4");
    put(8'h10, 1'b0);
    repeat (4) @(negedge clk);
    #2;
    check("R3", "stalled tx_valid", tx_valid, 1);
    check("R3", "stalled rx_ready", rx_ready, 0);
    @(negedge clk);
    tx_ready = 1'b1;
    drain("R4");
    check("R4", "pw_busy", pw_busy, 1);

    // R10 good password and checksum
    run_pw(-1, 1'b0, 8'h10, "R10");
    check("R10", "flags", {pw_err, cks_err}, 0);
    check("R10", "pw_busy", pw_busy, 0);

    // R8 last byte wrong
    expect_tx(8'h10, "R4");
    put(8'h10, 1'b0);
    run_pw(PW_LEN - 1, 1'b0, 8'h14, "R8");
    check("R8", "pw_err", pw_err, 1);
    check("R9", "cks_err", cks_err, 0);

    // R9 bad checksum, pw_err cleared by new command
    expect_tx(8'h10, "R4");
    put(8'h10, 1'b0);
    run_pw(-1, 1'b1, 8'h12, "R9");
    check("R8", "pw_err cleared", pw_err, 0);
    check("R9", "cks_err", cks_err, 1);

    // R8 sticky from first byte, both errors
    expect_tx(8'h10, "R4");
    put(8'h10, 1'b0);
    run_pw(0, 1'b1, 8'h16, "R8");
    check("R8", "pw_err sticky", pw_err, 1);

    // R6 synchronous mode ignores rx_err
    sync_mode = 1'b1;
    expect_tx(8'h10, "R6");
    put(8'h10, 1'b1);
    drain("R6");
    check("R6", "pw_busy", pw_busy, 1);
    run_pw(-1, 1'b0, 8'h10, "R6");
    expect_tx(8'h11, "R6");
    put(8'h44, 1'b1);
    drain("R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule